// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shifter

The block turns a parallel word into a bit stream. It has two stages. The first is a storage register that captures the parallel inputs on each rising edge of a latch strobe. The second is a shift register whose last stage drives the serial output. A mode input selects what the shift register does. In load mode it follows the storage register. In shift mode it moves one place toward the output on each rising edge of a shift strobe, and the serial input fills the first stage.

Everything runs on one system clock. The two strobes are asynchronous level inputs. Each one passes through a two-stage synchronizer and then an edge detector, so a strobe held high acts only once. The active-low clear input `clr_ni` empties only the shift register. The system reset `rst_ni` initializes both registers and the synchronizers. The mode, serial and parallel inputs are taken as synchronous to the clock. The parallel inputs must stay stable from the rise of the latch strobe until the capture.

Top module: `latched_piso_shifter`

## Requirements
- R1: The storage register captures `par_i` on the clock edge that detects a rising latch strobe. This is the third clock edge after the strobe rises. Between such edges the storage register holds its value.
- R2: In shift mode (`mode_i`=1), each detected rising edge of the shift strobe moves every stage N (bit N) to stage N+1. On that same clock edge, `sin_i` enters stage 0. The old top stage is dropped.
- R3: In load mode (`mode_i`=0), the shift register takes the storage register contents on every clock edge, with `par_i[k]` ending up in stage k. Changes on `par_i` without a latch strobe, the serial input and the shift strobe all have no effect.
- R4: In load mode, a latch strobe edge places the new word in the storage register and in the shift register on the same clock edge.
- R5: In shift mode, when the latch and shift strobe edges are detected together, the storage register takes the new word. The shift register shifts its old contents, not the new word.
- R6: In shift mode with no strobe edge, both registers keep their values.
- R7: While `clr_ni` is low, the shift register becomes 0 on the next clock edge and stays 0 in either mode. The storage register is not changed. After `clr_ni` is released in load mode, the shift register reloads from the storage register on the next clock edge.
- R8: While `rst_ni` is low (asynchronous), the storage register, the shift register and the synchronizers are all 0, so `sout_o` is 0.
- R9: A strobe held high for many cycles produces exactly one action.
- R10: `sout_o` is always the top stage (bit WIDTH-1) of the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| clr_ni | input | 1 | Active-low clear of the shift register only |
| mode_i | input | 1 | 1 = shift mode, 0 = load mode |
| latch_i | input | 1 | Latch strobe (asynchronous level, rising edge acts) |
| shift_i | input | 1 | Shift strobe (asynchronous level, rising edge acts) |
| sin_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel word; bit k feeds stage k |
| sout_o | output | 1 | Serial output, top stage of the shift register |

## Verification
A strobe rise is driven just after a falling clock edge. The synchronizer and the edge register place its action on the third rising edge after the strobe rises. One check samples `sout_o` after the second rising edge, to confirm that nothing has moved yet, and again after the third, to confirm the action landed. Mode changes and `clr_ni` act on the next rising edge, so their checks sample at the falling edge that follows. All other checks wait for a settled state and then compare `sout_o` against a bench model of both registers. Every one of the 256 words is latched, loaded and shifted out bit by bit.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } piso_mode_e;
endpackage

// File: rtl/piso_strobe_sync.sv
module piso_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= strobe_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // one action per strobe edge
  p_single_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/piso_input_store.sv
module piso_input_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (capture_i) word_q <= par_i;
  end

  assign word_o = word_q;

  p_store_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(word_o));
  p_store_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> word_o == $past(par_i));
endmodule

// File: rtl/piso_shift_stage.sv
module piso_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             shift_mode_i,
  input  logic             step_i,
  input  logic             sin_i,
  input  logic [WIDTH-1:0] load_word_i,
  output logic [WIDTH-1:0] word_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] sreg_q;
  logic [WIDTH-1:0] sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (!clr_ni)           sreg_d = '0;           // clear beats load
    else if (!shift_mode_i) sreg_d = load_word_i;
    else if (step_i)       sreg_d = {sreg_q[TOP-1:0], sin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= sreg_d;
  end

  assign word_o = sreg_q;

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> word_o == '0);
  p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && shift_mode_i && step_i) |=>
      word_o == {$past(word_o[TOP-1:0]), $past(sin_i)});
  p_shift_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && shift_mode_i && !step_i) |=> $stable(word_o));
endmodule

// File: rtl/latched_piso_shifter.sv
module latched_piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             mode_i,
  input  logic             latch_i,
  input  logic             shift_i,
  input  logic             sin_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             sout_o
);
  localparam int unsigned TOP = WIDTH - 1;

  piso_mode_e       mode;
  logic             shift_mode;
  logic             latch_rise;
  logic             shift_rise;
  logic [WIDTH-1:0] store_word;
  logic [WIDTH-1:0] load_word;
  logic [WIDTH-1:0] sreg_word;

  assign mode       = piso_mode_e'(mode_i);
  assign shift_mode = (mode == MODE_SHIFT);

  piso_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_latch_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (latch_i),
    .rise_o   (latch_rise)
  );

  piso_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_shift_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (shift_i),
    .rise_o   (shift_rise)
  );

  piso_input_store #(.WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (latch_rise),
    .par_i     (par_i),
    .word_o    (store_word)
  );

  // a latch edge in load mode reaches both stages in the same cycle
  assign load_word = latch_rise ? par_i : store_word;

  piso_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_ni       (clr_ni),
    .shift_mode_i (shift_mode),
    .step_i       (shift_rise),
    .sin_i        (sin_i),
    .load_word_i  (load_word),
    .word_o       (sreg_word)
  );

  assign sout_o = sreg_word[TOP];

  p_load_tracks_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_mode && clr_ni) |=> sreg_word == store_word);
  p_clear_keeps_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !latch_rise) |=> $stable(store_word));
  p_joint_edges_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_mode && clr_ni && latch_rise && shift_rise) |=>
      (store_word == $past(par_i)) &&
      (sreg_word == {$past(sreg_word[TOP-1:0]), $past(sin_i)}));
endmodule

// File: tb/latched_piso_shifter_test.sv
module latched_piso_shifter_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_ni = 1'b1;
  logic         mode_i = 1'b1;
  logic         latch_i = 1'b0;
  logic         shift_i = 1'b0;
  logic         sin_i = 1'b0;
  logic [W-1:0] par_i = '0;
  logic         sout_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] store_m = '0;
  logic [W-1:0] sreg_m  = '0;

  always #4 clk = ~clk;

  latched_piso_shifter #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_ni), .mode_i(mode_i),
    .latch_i(latch_i), .shift_i(shift_i), .sin_i(sin_i), .par_i(par_i),
    .sout_o(sout_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sout actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic strobe(input bit do_latch, input bit do_shift,
                        input logic [W-1:0] word, input logic b, input int hold);
    if (do_latch) par_i = word;
    sin_i   = b;
    latch_i = do_latch;
    shift_i = do_shift;
    repeat (hold) @(negedge clk);
    latch_i = 1'b0;
    shift_i = 1'b0;
    repeat (3) @(negedge clk);
    if (do_shift && mode_i) sreg_m = {sreg_m[W-2:0], b};
    if (do_latch) store_m = word;
    if (!mode_i && clr_ni) sreg_m = store_m;
  endtask

  task automatic set_mode(input logic m);
    mode_i = m;
    @(negedge clk);
    if (!m && clr_ni) sreg_m = store_m;
  endtask

  // R10: shift the whole register out through sout_o, checking each bit
  task automatic shift_out(input string req, input logic [W-1:0] fill);
    set_mode(1'b1);
    for (int i = 0; i < W; i++) begin
      chk(req, sout_o, sreg_m[W-1]);
      strobe(1'b0, 1'b1, '0, fill[W-1-i], 2);
    end
    chk(req, sout_o, sreg_m[W-1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] pre;
    repeat (3) @(negedge clk);
    chk("R8 reset", sout_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    set_mode(1'b0);
    chk("R8 storage zero after reset", sout_o, 1'b0);

    // R1/R3/R10 sweep over every word
    for (int w = 0; w < 256; w++) begin
      set_mode(1'b1);
      pre = sreg_m;
      strobe(1'b1, 1'b0, W'(w), 1'b0, 2);
      chk("R6 latch in shift mode leaves shift reg", sout_o, pre[W-1]);
      par_i = ~W'(w);                    // pins differ from stored word
      set_mode(1'b0);
      chk("R3 load from storage not pins", sout_o, W'(w) >> (W-1));
      shift_out("R10 word order", ~W'(w));
    end

    // R4: latch edge in load mode reaches shift reg at once
    set_mode(1'b0);
    strobe(1'b1, 1'b0, 8'hA5, 1'b0, 2);
    chk("R4 new bit h", sout_o, 1'b1);
    strobe(1'b1, 1'b0, 8'h5A, 1'b0, 2);
    chk("R4 new bit h", sout_o, 1'b0);
    shift_out("R4 full word", 8'h00);

    // R3: serial input and shift strobe ignored in load mode
    set_mode(1'b0);
    strobe(1'b1, 1'b0, 8'hC3, 1'b0, 2);
    for (int i = 0; i < 4; i++) begin
      strobe(1'b0, 1'b1, '0, i[0], 2);
      chk("R3 shift ignored in load mode", sout_o, 1'b1);
    end
    shift_out("R3 word intact", 8'hFF);

    // R5: joint edges in shift mode
    set_mode(1'b0);
    strobe(1'b1, 1'b0, 8'h81, 1'b0, 2);
    set_mode(1'b1);
    strobe(1'b1, 1'b1, 8'h7E, 1'b1, 2);  // shift old 81 -> 03
    chk("R5 shift uses old contents", sout_o, 1'b0);
    shift_out("R5 shifted old word", 8'h00);
    set_mode(1'b0);
    chk("R5 storage took new word", sout_o, 1'b0);
    shift_out("R5 new stored word", 8'h00);

    // R7: clear priority, storage kept, reload on release
    set_mode(1'b0);
    strobe(1'b1, 1'b0, 8'hF0, 1'b0, 2);
    chk("R7 loaded before clear", sout_o, 1'b1);
    clr_ni = 1'b0;
    @(negedge clk);
    chk("R7 clear", sout_o, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 clear holds in load mode", sout_o, 1'b0);
    clr_ni = 1'b1;
    @(negedge clk);
    chk("R7 reload after release", sout_o, 1'b1);
    sreg_m = store_m;
    set_mode(1'b1);
    clr_ni = 1'b0;
    @(negedge clk);
    clr_ni = 1'b1;
    sreg_m = '0;
    @(negedge clk);
    shift_out("R7 cleared in shift mode", 8'hFF);

    // R6: idle in shift mode
    repeat (20) @(negedge clk);
    shift_out("R6 hold", 8'h96);

    // R2 latency: action lands on third edge after strobe rise
    set_mode(1'b1);
    chk("R2 before", sout_o, 1'b1);        // 0x96 top bit
    sin_i = 1'b0;
    shift_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet after two edges", sout_o, 1'b1);
    @(negedge clk);
    chk("R2 shifted on third edge", sout_o, 1'b0);
    shift_i = 1'b0;
    repeat (3) @(negedge clk);
    sreg_m = {sreg_m[W-2:0], 1'b0};

    // R9: long strobe gives one shift
    pre = sreg_m;
    strobe(1'b0, 1'b1, '0, 1'b1, 12);
    chk("R9 single shift", sout_o, pre[W-2]);
    shift_out("R9 single shift word", 8'h00);

    // R8: async reset mid-run clears storage too
    set_mode(1'b0);
    strobe(1'b1, 1'b0, 8'hFF, 1'b0, 2);
    #1 rst_ni = 1'b0;
    #1 chk("R8 async reset", sout_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    store_m = '0;
    sreg_m  = '0;
    repeat (2) @(negedge clk);
    chk("R8 storage cleared", sout_o, 1'b0);

    summary();
  end
endmodule